// File: doc/BRIEF.md
# Single-Shot Comparator Sequencer

This block decides when an analog comparator is powered and when its output can be trusted. It has two modes. In continuous mode, setting the enable input powers the comparator. After a timed settling window the block marks its registered result valid, and from then on the result follows the comparator every cycle. In single-shot mode the comparator stays unpowered while enabled. Each start strobe runs one cycle of power-up, settling, a single sample and power-down. The end of that cycle is signalled by a one-cycle end-of-conversion pulse.

The settling window lasts `max(sut,1) << prescale` clock cycles, written N below. A zero `sut` counts as one, so the window is never skipped. Exchanging the inputs is handled inside the block. When `swap` is set, the two input-select codes change places and the raw comparator output is inverted before it is used. Hysteresis is passed to the analog side only while the comparator is powered in continuous mode.

The sequencer has four states. OFF means disabled. ARMED means enabled in single-shot mode, unpowered and waiting. WARM means powered and settling. LIVE means continuous with a valid result.

The transitions are:
- OFF→ARMED: enable with single-shot set.
- OFF→WARM: enable with single-shot clear.
- ARMED→WARM: start strobe, or single-shot cleared.
- WARM→ARMED: window done in single-shot mode; this transition samples the result once.
- WARM→LIVE: window done in continuous mode.
- LIVE→ARMED: single-shot set.
- Any state→OFF: enable low. This has priority over every other transition.

Top module: `acmp_shot_seq`

## Requirements
- R1: Under reset, and right after it, `pwr_en`, `hyst_en`, `valid`, `eoc` and `result` are all 0.
- R2: In continuous mode, `pwr_en` goes high in the cycle after `en` is sampled high. `valid` goes high after exactly N cycles in which `pwr_en` is high and `valid` is low.
- R3: While `en=1` and `single_mode=1`, `pwr_en` stays low until a start strobe is sampled in the ARMED state.
- R4: A start strobe sampled in ARMED holds `pwr_en` high for exactly N cycles and then drops it. At the last edge of that window, the corrected comparator value is stored in `result`.
- R5: `eoc` is high for exactly one cycle, and that is the cycle in which the single-shot `result` first shows the new sample. `valid` is 1 at that time and stays 1 until the next start strobe.
- R6: `hyst_en` equals `hyst_req` while the comparator is powered in continuous mode. It is always 0 in single-shot mode.
- R7: With `swap=1`, `sel_pos_out` carries `sel_neg_in`, `sel_neg_out` carries `sel_pos_in`, and the comparator output is inverted. With `swap=0` the selects pass straight through. In LIVE, `result` shows the corrected comparator value from the previous cycle.
- R8: A `sut` of 0 gives the same window as a `sut` of 1, that is, `1 << prescale` cycles.
- R9: A start strobe has no effect outside ARMED. This covers a strobe during a running shot and a strobe while disabled: no extra power cycle and no extra `eoc`.
- R10: Dropping `en` forces `pwr_en` low in the same cycle. `valid` is low from the next cycle on, and an aborted shot produces no `eoc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Comparator enable |
| single_mode | input | 1 | 1 = single-shot, 0 = continuous |
| start | input | 1 | Start strobe for a single-shot cycle |
| sut | input | SUT_W | Start-up time count (0 treated as 1) |
| prescale | input | PRE_W | Start-up time scale exponent |
| swap | input | 1 | Exchange input selects and invert output |
| hyst_req | input | 1 | Hysteresis requested |
| sel_pos_in | input | SEL_W | Requested positive input select |
| sel_neg_in | input | SEL_W | Requested negative input select |
| cmp_raw | input | 1 | Raw comparator output (already synchronous) |
| pwr_en | output | 1 | Analog power enable |
| hyst_en | output | 1 | Hysteresis enable to analog |
| sel_pos_out | output | SEL_W | Positive select after swap |
| sel_neg_out | output | SEL_W | Negative select after swap |
| result | output | 1 | Registered, swap-corrected result |
| valid | output | 1 | Result is valid |
| eoc | output | 1 | End-of-comparison pulse |

## Verification
The timing is tried with random `sut` and `prescale` pairs. Each power-high window is measured and compared with N. This separates a correct window from an off-by-one count, from a lost prescale shift, and from a zero `sut` that skips settling.

The comparator input is randomised on every cycle of a shot. A correct capture edge is then the only way to produce the expected `result`, and running with `swap` set and clear separates a correct inversion from a missing one.

Directed cases cover the rejected strobes:
- an extra start during a shot;
- a start while disabled;
- an abort in the middle of a shot.

These cases show whether a strobe is wrongly accepted, by an extra power window or an extra `eoc`, and whether power falls without delay when the block is disabled.

// File: rtl/acmp_seq_pkg.sv
package acmp_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_WARM  = 2'd2,
        SEQ_LIVE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/acmp_settle_timer.sv
module acmp_settle_timer #(
    parameter int SUT_W = 6,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SUT_W-1:0] sut,
    input  logic [PRE_W-1:0] prescale,
    output logic             zero
);
    localparam int CNT_W = SUT_W + (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SUT_W-1:0] sut_eff;
    logic [CNT_W-1:0] span;

    // A zero start-up count would skip settling; clamp it to one.
    assign sut_eff = (sut == '0) ? SUT_W'(1) : sut;
    assign span    = CNT_W'(sut_eff) << prescale;
    assign zero    = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= span - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/acmp_seq_fsm.sv
module acmp_seq_fsm
    import acmp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic single_mode,
    input  logic start,
    input  logic tmr_zero,
    output logic load,
    output logic capture,
    output logic pwr,
    output logic valid,
    output logic eoc
);
    seq_state_e state_q, state_n;
    logic       done;
    logic       valid_q, eoc_q;

    // Window ends in the last WARM cycle, unless enable has been dropped.
    assign done = (state_q == SEQ_WARM) && tmr_zero && en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!en) begin
            state_n = SEQ_OFF;
        end else begin
            unique case (state_q)
                SEQ_OFF:   state_n = single_mode ? SEQ_ARMED : SEQ_WARM;
                SEQ_ARMED: if (!single_mode || start) state_n = SEQ_WARM;
                SEQ_WARM:  if (tmr_zero) state_n = single_mode ? SEQ_ARMED : SEQ_LIVE;
                SEQ_LIVE:  if (single_mode) state_n = SEQ_ARMED;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        load    = (state_n == SEQ_WARM) && (state_q != SEQ_WARM);
        capture = done || ((state_q == SEQ_LIVE) && en);
        pwr     = en && ((state_q == SEQ_WARM) || (state_q == SEQ_LIVE));
    end

    // Registered flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            eoc_q   <= 1'b0;
        end else begin
            eoc_q <= done && single_mode;
            if (done)
                valid_q <= 1'b1;
            else if (state_n == SEQ_OFF || state_n == SEQ_WARM)
                valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign eoc   = eoc_q;

endmodule

// File: rtl/acmp_result_path.sv
module acmp_result_path #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap,
    input  logic             capture,
    input  logic [SEL_W-1:0] sel_pos_in,
    input  logic [SEL_W-1:0] sel_neg_in,
    input  logic             cmp_raw,
    output logic [SEL_W-1:0] sel_pos_out,
    output logic [SEL_W-1:0] sel_neg_out,
    output logic             result
);
    logic cmp_fix;
    logic result_q;

    assign sel_pos_out = swap ? sel_neg_in : sel_pos_in;
    assign sel_neg_out = swap ? sel_pos_in : sel_neg_in;
    assign cmp_fix     = cmp_raw ^ swap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result_q <= 1'b0;
        else if (capture) result_q <= cmp_fix;
    end

    assign result = result_q;

endmodule

// File: rtl/acmp_shot_seq.sv
module acmp_shot_seq #(
    parameter int SUT_W = 6,
    parameter int PRE_W = 3,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             single_mode,
    input  logic             start,
    input  logic [SUT_W-1:0] sut,
    input  logic [PRE_W-1:0] prescale,
    input  logic             swap,
    input  logic             hyst_req,
    input  logic [SEL_W-1:0] sel_pos_in,
    input  logic [SEL_W-1:0] sel_neg_in,
    input  logic             cmp_raw,
    output logic             pwr_en,
    output logic             hyst_en,
    output logic [SEL_W-1:0] sel_pos_out,
    output logic [SEL_W-1:0] sel_neg_out,
    output logic             result,
    output logic             valid,
    output logic             eoc
);
    logic tmr_zero, tmr_load, capture, pwr;

    acmp_settle_timer #(.SUT_W(SUT_W), .PRE_W(PRE_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .sut      (sut),
        .prescale (prescale),
        .zero     (tmr_zero)
    );

    acmp_seq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .single_mode (single_mode),
        .start       (start),
        .tmr_zero    (tmr_zero),
        .load        (tmr_load),
        .capture     (capture),
        .pwr         (pwr),
        .valid       (valid),
        .eoc         (eoc)
    );

    acmp_result_path #(.SEL_W(SEL_W)) i_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap        (swap),
        .capture     (capture),
        .sel_pos_in  (sel_pos_in),
        .sel_neg_in  (sel_neg_in),
        .cmp_raw     (cmp_raw),
        .sel_pos_out (sel_pos_out),
        .sel_neg_out (sel_neg_out),
        .result      (result)
    );

    assign pwr_en  = pwr;
    assign hyst_en = pwr && hyst_req && !single_mode;

endmodule

// File: rtl/acmp_shot_seq_chk.sv
module acmp_shot_seq_chk #(
    parameter int SUT_W = 6,
    parameter int PRE_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             single_mode,
    input logic             start,
    input logic [SUT_W-1:0] sut,
    input logic [PRE_W-1:0] prescale,
    input logic             swap,
    input logic             cmp_raw,
    input logic             pwr_en,
    input logic             hyst_en,
    input logic             result,
    input logic             valid,
    input logic             eoc
);
    localparam int CNT_W = SUT_W + (1 << PRE_W);

    logic [CNT_W-1:0] warm_cnt;
    logic [CNT_W-1:0] span_exp;

    assign span_exp = (sut == '0) ? (CNT_W'(1) << prescale) : (CNT_W'(sut) << prescale);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (!pwr_en)        warm_cnt <= '0;
        else if (!valid)         warm_cnt <= warm_cnt + CNT_W'(1);
    end

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid) && !single_mode) |-> (warm_cnt == span_exp));

    // R3
    armed_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && single_mode && !pwr_en && !start) |=> !pwr_en);

    // R4
    shot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_en) && en && !$past(valid)) |-> eoc);

    // R5
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    // R5
    eoc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> valid);

    // R6
    no_hyst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_mode |-> !hyst_en);

    // R7
    swap_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && valid && $past(pwr_en) && $past(valid))
            |-> (result == ($past(cmp_raw) ^ $past(swap))));

    // R10
    abort_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwr_en);

    // R10
    abort_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!valid && !eoc));

endmodule

bind acmp_shot_seq acmp_shot_seq_chk #(.SUT_W(SUT_W), .PRE_W(PRE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .single_mode (single_mode),
    .start       (start),
    .sut         (sut),
    .prescale    (prescale),
    .swap        (swap),
    .cmp_raw     (cmp_raw),
    .pwr_en      (pwr_en),
    .hyst_en     (hyst_en),
    .result      (result),
    .valid       (valid),
    .eoc         (eoc)
);

// File: tb/test_acmp_shot_seq.sv
`timescale 1ns/1ps
module test_acmp_shot_seq;
    localparam int SUT_W = 6;
    localparam int PRE_W = 3;
    localparam int SEL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, single_mode = 1'b0, start = 1'b0;
    logic [SUT_W-1:0] sut = '0;
    logic [PRE_W-1:0] prescale = '0;
    logic swap = 1'b0, hyst_req = 1'b0, cmp_raw = 1'b0;
    logic [SEL_W-1:0] sel_pos_in = '0, sel_neg_in = '0;
    logic pwr_en, hyst_en, result, valid, eoc;
    logic [SEL_W-1:0] sel_pos_out, sel_neg_out;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acmp_shot_seq #(.SUT_W(SUT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) i_acmp_shot_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .single_mode(single_mode), .start(start),
        .sut(sut), .prescale(prescale), .swap(swap), .hyst_req(hyst_req),
        .sel_pos_in(sel_pos_in), .sel_neg_in(sel_neg_in), .cmp_raw(cmp_raw),
        .pwr_en(pwr_en), .hyst_en(hyst_en), .sel_pos_out(sel_pos_out),
        .sel_neg_out(sel_neg_out), .result(result), .valid(valid), .eoc(eoc)
    );

    function automatic int exp_span(int s, int p);
        return ((s == 0) ? 1 : s) << p;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic setup(int s, int p, bit sw, bit hy, bit sm);
        en = 1'b0; start = 1'b0;
        step();
        sut = SUT_W'(s); prescale = PRE_W'(p); swap = sw; hyst_req = hy; single_mode = sm;
        sel_pos_in = SEL_W'($urandom); sel_neg_in = SEL_W'($urandom);
        step();
    endtask

    task automatic run_cont(int s, int p, bit sw, bit hy);
        int cnt = 0;
        int guard = 0;
        string rq = (s == 0) ? "R8" : "R2";
        setup(s, p, sw, hy, 1'b0);
        en = 1'b1;
        step();
        chk(pwr_en == 1'b1, "R2 power after enable", pwr_en, 1);
        while (!valid && guard < 20000) begin
            if (pwr_en) cnt++;
            cmp_raw = 1'($urandom);
            step();
            guard++;
        end
        chk(cnt == exp_span(s, p), rq, cnt, exp_span(s, p));
        chk(hyst_en == hy, "R6 continuous hysteresis", hyst_en, hy);
        chk(sel_pos_out == (sw ? sel_neg_in : sel_pos_in), "R7 pos select", sel_pos_out, sw ? sel_neg_in : sel_pos_in);
        chk(sel_neg_out == (sw ? sel_pos_in : sel_neg_in), "R7 neg select", sel_neg_out, sw ? sel_pos_in : sel_neg_in);
        for (int i = 0; i < 8; i++) begin
            bit d = 1'($urandom);
            cmp_raw = d;
            step();
            chk(result == (d ^ sw), "R7 live result", result, d ^ sw);
        end
        en = 1'b0;
        #1;
        chk(pwr_en == 1'b0, "R10 power drops at once", pwr_en, 0);
        step();
        chk(valid == 1'b0, "R10 valid cleared", valid, 0);
    endtask

    task automatic run_shot(int s, int p, bit sw, bit hy, bit extra);
        int cnt = 0;
        int guard = 0;
        int n = exp_span(s, p);
        string rq = (s == 0) ? "R8" : "R4";
        setup(s, p, sw, hy, 1'b1);
        en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(pwr_en == 1'b0, "R3 armed unpowered", pwr_en, 0);
        end
        start = 1'b1;
        step();
        start = 1'b0;
        while (!eoc && guard < 20000) begin
            chk(hyst_en == 1'b0, "R6 no hysteresis in single", hyst_en, 0);
            if (pwr_en) cnt++;
            start = (extra && cnt == 2) ? 1'b1 : 1'b0;
            cmp_raw = 1'($urandom);
            step();
            guard++;
        end
        start = 1'b0;
        chk(cnt == n, rq, cnt, n);
        chk(result == (cmp_raw ^ sw), "R4 captured result", result, cmp_raw ^ sw);
        chk(valid == 1'b1, "R5 valid with eoc", valid, 1);
        chk(pwr_en == 1'b0, "R4 power down after shot", pwr_en, 0);
        step();
        chk(eoc == 1'b0, "R5 eoc one cycle", eoc, 0);
        chk(valid == 1'b1, "R5 valid held", valid, 1);
        for (int i = 0; i < 6; i++) begin
            step();
            chk(pwr_en == 1'b0 && eoc == 1'b0, "R9 no extra shot", pwr_en, 0);
        end
        en = 1'b0;
        step();
    endtask

    initial begin
        void'($urandom(32'd4711));
        #1;
        chk(pwr_en == 0 && valid == 0 && eoc == 0 && hyst_en == 0 && result == 0, "R1 in reset", pwr_en, 0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(pwr_en == 0 && valid == 0 && eoc == 0 && hyst_en == 0 && result == 0, "R1 after reset", valid, 0);

        // Directed corners
        run_cont(1, 0, 1'b0, 1'b1);
        run_cont(0, 2, 1'b1, 1'b1);
        run_shot(0, 0, 1'b1, 1'b1, 1'b0);
        run_shot(3, 1, 1'b0, 1'b1, 1'b1);
        run_shot(2, 0, 1'b1, 1'b0, 1'b1);

        // Start while disabled
        setup(4, 1, 1'b0, 1'b0, 1'b1);
        start = 1'b1;
        step();
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(pwr_en == 1'b0, "R9 start while disabled", pwr_en, 0);
            step();
        end

        // Abort in the middle of a shot
        setup(10, 2, 1'b0, 1'b0, 1'b1);
        en = 1'b1;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (5) step();
        chk(pwr_en == 1'b1, "R4 powered during shot", pwr_en, 1);
        en = 1'b0;
        #1;
        chk(pwr_en == 1'b0, "R10 abort drops power", pwr_en, 0);
        for (int i = 0; i < 50; i++) begin
            step();
            chk(eoc == 1'b0 && valid == 1'b0, "R10 no eoc after abort", eoc, 0);
        end

        // Random trials
        for (int t = 0; t < 8; t++) begin
            run_cont($urandom_range(0, 12), $urandom_range(0, 3), 1'($urandom), 1'($urandom));
            run_shot($urandom_range(0, 12), $urandom_range(0, 3), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule